// File: doc/BRIEF.md
# Block Transfer Disk Controller

This controller sits in the I/O region of the address map and moves whole 4096-byte blocks between a block-storage port and main memory. Software first writes a word-aligned memory address into the address register. It then writes the control word, which holds a direction bit, an interrupt-enable bit and a 20-bit block number. That single control write starts the whole transfer. The controller then copies one 32-bit word per cycle, in ascending order, through a memory master port and a block-storage port. Both ports are modelled as synchronous single-port stores with a fixed read latency.

While words are moving, the status register shows busy. Busy drops at the clock edge that also raises a one-cycle completion interrupt, but only when interrupt enable was set in the command. A control write that arrives while busy is dropped entirely. The block size is set by the word count, and the read latency of both stores is a parameter. Latency 1 and deeper pipelines are built as separate variants.

Top module: `blkdisk_ctrl`

## Requirements
- R1: After reset, busy and the interrupt are low, the control and address registers read 0, and neither port issues a request.
- R2: A write to the control register (offset 0x0 from the base 0xF0000000) while idle is accepted: status bit 0 reads 1 from the next cycle.
- R3: Control bit 0 = 0 (load) copies block-store words 0..WORDS_PER_BLK-1 of the block in control bits 21:2 to memory byte addresses A, A+4, A+8, … in that order. A is the address register with bits 1:0 cleared. No other memory word changes.
- R4: Control bit 0 = 1 (store) copies memory words from A upward into the selected block, at block-store address {block, word index}. Other blocks are left unchanged.
- R5: Bits 1:0 of the address register have no effect on where the transfer lands.
- R6: Busy falls at the same edge where the interrupt goes high for exactly one cycle. This happens only when control bit 1 (interrupt enable) was 1 in the accepted command; with bit 1 = 0 there is no interrupt.
- R7: A control write while busy is ignored: the control readback keeps the accepted value, and the running transfer keeps its direction, block and length.
- R8: The control register (offset 0x0) and the address register (offset 0x4) read back the last accepted value, all 32 bits. The status register (offset 0x8) has bits 31:1 equal to 0. Unmapped offsets read 0.
- R9: Busy stays high for exactly WORDS_PER_BLK + RD_LAT cycles per transfer.
- R10: Memory and block store are never written in the same cycle, and every block-store access carries the accepted block number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | Register write strobe |
| io_addr | input | ADDR_W | Register byte address |
| io_wdata | input | DATA_W | Register write data |
| io_rdata | output | DATA_W | Register read data, decoded from io_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, RD_LAT cycles after a read |
| dsk_req | output | 1 | Block-store access request |
| dsk_we | output | 1 | Block-store write (1) or read (0) |
| dsk_addr | output | BLK_NUM_W+log2(WORDS_PER_BLK) | Block number and word index |
| dsk_wdata | output | DATA_W | Block-store write data |
| dsk_rdata | input | DATA_W | Block-store read data, RD_LAT cycles after a read |
| irq_done | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach is a second control write landing in the middle of a running transfer. It has to arrive on a chosen cycle, well after acceptance and before the final write. The bench counts busy cycles while the transfer runs and drives a conflicting control word on the third busy cycle. It then confirms that the readback, the duration and every copied word still match the first command. A sweep over block numbers, both directions, both interrupt settings and every low address pattern covers the alignment and masking corners, with neighbouring words checked for stray writes.

// File: rtl/blkdisk_pkg.sv
package blkdisk_pkg;

   // Control word field positions (decoded by software drivers)
   localparam int CTRL_CMD_BIT  = 0;
   localparam int CTRL_IE_BIT   = 1;
   localparam int CTRL_BLK_LSB  = 2;
   localparam int BLK_NUM_W_DEF = 20;

   // Register offsets within the 16-byte window
   localparam logic [3:0] OFS_CTRL  = 4'h0;
   localparam logic [3:0] OFS_MADDR = 4'h4;
   localparam logic [3:0] OFS_STAT  = 4'h8;

   typedef enum logic {
      CMD_LOAD  = 1'b0,
      CMD_STORE = 1'b1
   } xfer_cmd_e;

endpackage

// File: rtl/blkdisk_regs.sv
module blkdisk_regs
   import blkdisk_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hF000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_we,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              busy,
   output logic [DATA_W-1:0] io_rdata,
   output logic              start,
   output logic [DATA_W-1:0] maddr_q
);

   localparam int DEC_LSB = 4;

   if (BASE_ADDR[DEC_LSB-1:0] != '0) begin : g_bad_base
      $error("BASE_ADDR must be 16-byte aligned");
   end

   logic              hit_blk;
   logic [3:0]        sel;
   logic              hit_ctrl;
   logic              hit_maddr;
   logic [DATA_W-1:0] ctrl_q;

   assign hit_blk   = (io_addr[ADDR_W-1:DEC_LSB] == BASE_ADDR[ADDR_W-1:DEC_LSB]);
   assign sel       = io_addr[DEC_LSB-1:0];
   assign hit_ctrl  = hit_blk && (sel == OFS_CTRL);
   assign hit_maddr = hit_blk && (sel == OFS_MADDR);
   assign start     = io_we && hit_ctrl && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         maddr_q <= '0;
      end else begin
         if (start) ctrl_q <= io_wdata;
         if (io_we && hit_maddr) maddr_q <= io_wdata;
      end
   end

   always_comb begin
      io_rdata = '0;
      if (hit_blk) begin
         case (sel)
            OFS_CTRL:  io_rdata = ctrl_q;
            OFS_MADDR: io_rdata = maddr_q;
            OFS_STAT:  io_rdata = DATA_W'(busy);
            default:   io_rdata = '0;
         endcase
      end
   end

   // R7: a control write during a transfer leaves the stored command alone
   assert_busy_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && hit_ctrl && busy) |=> $stable(ctrl_q));

endmodule

// File: rtl/blkdisk_xfer.sv
module blkdisk_xfer
   import blkdisk_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter int BLK_NUM_W     = BLK_NUM_W_DEF,
   parameter int WORDS_PER_BLK = 1024,
   parameter int RD_LAT        = 1,
   localparam int IDX_W        = $clog2(WORDS_PER_BLK)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  xfer_cmd_e            start_cmd,
   input  logic                 start_ie,
   input  logic [BLK_NUM_W-1:0] start_blk,
   input  logic [ADDR_W-1:0]    start_maddr,
   output logic                 busy,
   output logic                 irq_done,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [DATA_W-1:0]    mem_wdata,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic                 dsk_req,
   output logic                 dsk_we,
   output logic [BLK_NUM_W+IDX_W-1:0] dsk_addr,
   output logic [DATA_W-1:0]    dsk_wdata,
   input  logic [DATA_W-1:0]    dsk_rdata
);

   localparam int CNT_W    = IDX_W + 1;
   localparam int ADDR_LSB = $clog2(DATA_W / 8);
   localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(WORDS_PER_BLK);
   localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(WORDS_PER_BLK - 1);
   localparam logic [ADDR_W-1:0] LSB_MASK = ADDR_W'((1 << ADDR_LSB) - 1);

   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if (WORDS_PER_BLK < 2 || (1 << IDX_W) != WORDS_PER_BLK) begin : g_bad_words
      $error("WORDS_PER_BLK must be a power of two, at least 2");
   end
   if (DATA_W % 8 != 0 || (1 << ADDR_LSB) * 8 != DATA_W) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end

   // Job latched at acceptance
   logic                 busy_q;
   logic                 irq_q;
   xfer_cmd_e            job_cmd;
   logic                 job_ie;
   logic [BLK_NUM_W-1:0] job_blk;
   logic [ADDR_W-1:0]    job_base;
   logic [CNT_W-1:0]     rd_cnt;

   logic             issuing;
   logic [IDX_W-1:0] rd_idx;
   logic             wr_v;
   logic [IDX_W-1:0] wr_idx;
   logic             last_wr;
   logic             is_load;

   assign issuing = busy_q && (rd_cnt != CNT_END);
   assign rd_idx  = rd_cnt[IDX_W-1:0];
   assign last_wr = wr_v && (wr_idx == IDX_LAST);
   assign is_load = (job_cmd == CMD_LOAD);

   // Read-to-write alignment: variant chosen by the source latency
   if (RD_LAT == 1) begin : g_lat_one
      logic             v_q;
      logic [IDX_W-1:0] i_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            i_q <= '0;
         end else begin
            v_q <= issuing;
            i_q <= rd_idx;
         end
      end
      assign wr_v   = v_q;
      assign wr_idx = i_q;
   end else begin : g_lat_deep
      logic [RD_LAT-1:0] v_pipe;
      logic [IDX_W-1:0]  i_pipe [RD_LAT];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_pipe <= '0;
            for (int s = 0; s < RD_LAT; s++) i_pipe[s] <= '0;
         end else begin
            v_pipe[0] <= issuing;
            i_pipe[0] <= rd_idx;
            for (int s = 1; s < RD_LAT; s++) begin
               v_pipe[s] <= v_pipe[s-1];
               i_pipe[s] <= i_pipe[s-1];
            end
         end
      end
      assign wr_v   = v_pipe[RD_LAT-1];
      assign wr_idx = i_pipe[RD_LAT-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         irq_q    <= 1'b0;
         job_cmd  <= CMD_LOAD;
         job_ie   <= 1'b0;
         job_blk  <= '0;
         job_base <= '0;
         rd_cnt   <= '0;
      end else begin
         irq_q <= 1'b0;
         if (start) begin
            busy_q   <= 1'b1;
            job_cmd  <= start_cmd;
            job_ie   <= start_ie;
            job_blk  <= start_blk;
            job_base <= start_maddr & ~LSB_MASK;
            rd_cnt   <= '0;
         end else begin
            if (issuing) rd_cnt <= rd_cnt + 1'b1;
            if (last_wr) begin
               busy_q <= 1'b0;
               irq_q  <= job_ie;
            end
         end
      end
   end

   logic [IDX_W-1:0] m_idx;
   logic [IDX_W-1:0] d_idx;

   assign m_idx     = is_load ? wr_idx : rd_idx;
   assign d_idx     = is_load ? rd_idx : wr_idx;
   assign mem_req   = is_load ? wr_v : issuing;
   assign mem_we    = is_load && wr_v;
   assign mem_addr  = job_base + (ADDR_W'(m_idx) << ADDR_LSB);
   assign mem_wdata = dsk_rdata;
   assign dsk_req   = is_load ? issuing : wr_v;
   assign dsk_we    = !is_load && wr_v;
   assign dsk_addr  = {job_blk, d_idx};
   assign dsk_wdata = mem_rdata;
   assign busy      = busy_q;
   assign irq_done  = irq_q;

   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy_q);

   assert_start_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);

   assert_irq_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $fell(busy_q));

   assert_irq_follows_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (irq_q == job_ie));

   assert_single_writer_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && dsk_we));

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !(mem_req || dsk_req));

   assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= CNT_END);

endmodule

// File: rtl/blkdisk_ctrl.sv
module blkdisk_ctrl
   import blkdisk_pkg::*;
#(
   parameter int                ADDR_W        = 32,
   parameter int                DATA_W        = 32,
   parameter int                BLK_NUM_W     = BLK_NUM_W_DEF,
   parameter int                WORDS_PER_BLK = 1024,
   parameter int                RD_LAT        = 1,
   parameter logic [ADDR_W-1:0] BASE_ADDR     = 32'hF000_0000,
   localparam int               IDX_W         = $clog2(WORDS_PER_BLK),
   localparam int               DADDR_W       = BLK_NUM_W + IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_we,
   input  logic [ADDR_W-1:0]  io_addr,
   input  logic [DATA_W-1:0]  io_wdata,
   output logic [DATA_W-1:0]  io_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               dsk_req,
   output logic               dsk_we,
   output logic [DADDR_W-1:0] dsk_addr,
   output logic [DATA_W-1:0]  dsk_wdata,
   input  logic [DATA_W-1:0]  dsk_rdata,
   output logic               irq_done
);

   if (DATA_W < CTRL_BLK_LSB + BLK_NUM_W) begin : g_bad_ctrl
      $error("control word too narrow for the block number");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("address register must fit a data word");
   end

   logic              busy;
   logic              start;
   logic [DATA_W-1:0] maddr_q;

   blkdisk_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_we    (io_we),
      .io_addr  (io_addr),
      .io_wdata (io_wdata),
      .busy     (busy),
      .io_rdata (io_rdata),
      .start    (start),
      .maddr_q  (maddr_q)
   );

   blkdisk_xfer #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .BLK_NUM_W     (BLK_NUM_W),
      .WORDS_PER_BLK (WORDS_PER_BLK),
      .RD_LAT        (RD_LAT)
   ) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_cmd   (xfer_cmd_e'(io_wdata[CTRL_CMD_BIT])),
      .start_ie    (io_wdata[CTRL_IE_BIT]),
      .start_blk   (io_wdata[CTRL_BLK_LSB +: BLK_NUM_W]),
      .start_maddr (maddr_q[ADDR_W-1:0]),
      .busy        (busy),
      .irq_done    (irq_done),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .dsk_req     (dsk_req),
      .dsk_we      (dsk_we),
      .dsk_addr    (dsk_addr),
      .dsk_wdata   (dsk_wdata),
      .dsk_rdata   (dsk_rdata)
   );

endmodule

// File: tb/test_blkdisk_ctrl.sv
module test_blkdisk_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int WORDS      = 16;
   localparam int IDXW       = 4;
   localparam int LAT        = 1;
   localparam int BLKW       = 20;
   localparam int DAW        = BLKW + IDXW;
   localparam logic [31:0] BASE = 32'hF000_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            io_we = 1'b0;
   logic [31:0]     io_addr = '0;
   logic [31:0]     io_wdata = '0;
   logic [31:0]     io_rdata;
   logic            mem_req, mem_we, dsk_req, dsk_we, irq_done;
   logic [31:0]     mem_addr, mem_wdata, dsk_wdata;
   logic [31:0]     mem_rdata = '0;
   logic [31:0]     dsk_rdata = '0;
   logic [DAW-1:0]  dsk_addr;

   logic [31:0] mem [256];
   logic [31:0] dsk [64];
   logic [BLKW-1:0] exp_blk = '0;
   logic addr_err = 1'b0;
   logic both_err = 1'b0;

   int total = 0;
   int bad   = 0;

   blkdisk_ctrl #(
      .WORDS_PER_BLK (WORDS),
      .RD_LAT        (LAT)
   ) i_blkdisk_ctrl (
      .clk (clk), .rst_n (rst_n),
      .io_we (io_we), .io_addr (io_addr), .io_wdata (io_wdata), .io_rdata (io_rdata),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
      .dsk_req (dsk_req), .dsk_we (dsk_we), .dsk_addr (dsk_addr),
      .dsk_wdata (dsk_wdata), .dsk_rdata (dsk_rdata),
      .irq_done (irq_done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Storage models, one-cycle read latency
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_addr[31:10] != '0) addr_err <= 1'b1;
         if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[9:2]];
      end
      if (dsk_req) begin
         if (dsk_addr[DAW-1:IDXW] != exp_blk) addr_err <= 1'b1;
         if (dsk_we) dsk[{dsk_addr[IDXW+1:IDXW], dsk_addr[IDXW-1:0]}] <= dsk_wdata;
         else        dsk_rdata <= dsk[{dsk_addr[IDXW+1:IDXW], dsk_addr[IDXW-1:0]}];
      end
      if (mem_we && dsk_we) both_err <= 1'b1;
   end

   function automatic logic [31:0] mem_pat(input int j, input logic [31:0] seed);
      return 32'hA000_0000 ^ (32'(j) * 32'h0101_0101) ^ seed;
   endfunction

   function automatic logic [31:0] dsk_pat(input int k, input logic [31:0] seed);
      return 32'hD000_0000 ^ (32'(k) << 12) ^ seed ^ 32'(k);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic io_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      io_we = 1'b1; io_addr = a; io_wdata = d;
      @(negedge clk);
      io_we = 1'b0; io_addr = '0;
   endtask

   task automatic io_read(input logic [31:0] a, output logic [31:0] d);
      io_addr = a;
      #1;
      d = io_rdata;
   endtask

   task automatic run_xfer(input bit cmd, input bit ie, input int b, input int low, input bit poke);
      logic [31:0] seed, maddr, ctrl, rd;
      logic [BLKW-1:0] blk_full;
      int wbase, cnt;
      seed     = 32'h1357_0000 ^ (32'(b) << 4) ^ 32'({cmd, ie});
      wbase    = b * 64 + 8;
      maddr    = 32'(wbase * 4) | 32'(low);
      blk_full = {2'b10, 16'h5A00 + 16'(b), 2'(b)};
      ctrl     = {10'h155, blk_full, ie, cmd};
      for (int j = 0; j < 256; j++) mem[j] = mem_pat(j, seed);
      for (int k = 0; k < 64; k++)  dsk[k] = dsk_pat(k, seed);
      exp_blk  = blk_full;
      addr_err = 1'b0;
      both_err = 1'b0;
      io_write(BASE + 32'h4, maddr);
      io_write(BASE, ctrl);
      io_read(BASE + 32'h8, rd);
      chk("R2 busy after accept", rd, 32'h1);
      io_read(BASE + 32'h4, rd);
      chk("R8 address readback", rd, maddr);
      cnt = 0;
      while (i_blkdisk_ctrl.busy === 1'b1 || cnt == 0) begin
         io_read(BASE + 32'h8, rd);
         if (rd != 32'h1) break;
         cnt++;
         if (poke && cnt == 3) begin
            io_we = 1'b1; io_addr = BASE; io_wdata = ctrl ^ 32'h0000_0FFF;
         end else begin
            io_we = 1'b0;
         end
         if (cnt > 4 * WORDS) break;
         @(negedge clk);
      end
      io_we = 1'b0;
      chk("R9 busy cycles", 32'(cnt), 32'(WORDS + LAT));
      chk("R6 irq at busy fall", 32'(irq_done), 32'(ie));
      io_read(BASE, rd);
      chk(poke ? "R7 ctrl readback after busy write" : "R8 ctrl readback", rd, ctrl);
      @(negedge clk);
      chk("R6 irq one cycle", 32'(irq_done), 32'h0);
      chk("R10 block number / address range", 32'(addr_err), 32'h0);
      chk("R10 single writer", 32'(both_err), 32'h0);
      if (cmd == 1'b0) begin
         for (int i = 0; i < WORDS; i++)
            chk(low != 0 ? "R5 load aligned data" : "R3 load data",
                mem[wbase + i], dsk_pat(b * WORDS + i, seed));
         chk("R3 word below untouched", mem[wbase - 1], mem_pat(wbase - 1, seed));
         chk("R3 word above untouched", mem[wbase + WORDS], mem_pat(wbase + WORDS, seed));
      end else begin
         for (int i = 0; i < WORDS; i++)
            chk(low != 0 ? "R5 store aligned data" : "R4 store data",
                dsk[b * WORDS + i], mem_pat(wbase + i, seed));
         chk("R4 other block untouched", dsk[(b ^ 1) * WORDS + 5], dsk_pat((b ^ 1) * WORDS + 5, seed));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      io_read(BASE, rd);           chk("R1 ctrl after reset", rd, 32'h0);
      io_read(BASE + 32'h4, rd);   chk("R1 address after reset", rd, 32'h0);
      io_read(BASE + 32'h8, rd);   chk("R1 status after reset", rd, 32'h0);
      chk("R1 irq after reset", 32'(irq_done), 32'h0);
      chk("R1 no requests after reset", 32'({mem_req, dsk_req}), 32'h0);
      io_read(BASE + 32'hC, rd);   chk("R8 unmapped offset", rd, 32'h0);
      io_read(32'hE000_0000, rd);  chk("R8 outside window", rd, 32'h0);

      for (int b = 0; b < 4; b++)
         for (int c = 0; c < 2; c++)
            for (int e = 0; e < 2; e++)
               run_xfer(c[0], e[0], b, (b + c + e) % 4, (b == 1 && e == 1));

      run_xfer(1'b0, 1'b1, 2, 3, 1'b1);
      run_xfer(1'b1, 1'b0, 3, 0, 1'b1);

      io_read(BASE + 32'h8, rd);
      chk("R8 status idle", rd, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule